// File: doc/BRIEF.md
# ALU Status Flag Register

This block holds the 16-bit status word that sits next to an integer ALU. After each 8-bit or 16-bit add, subtract or logic operation it derives the condition flags (carry, parity, half carry, zero, sign and overflow). It takes them from the two operands, the result and the carry out that the datapath supplies. A byte/word select picks which bit of the result counts as the sign bit and how much of the result the zero test covers.

Three control flags (trap, interrupt enable and direction) are held apart from the condition flags. Only dedicated set and clear strobes, or a parallel load of the whole word, change them. An ALU update never touches them. The unused bit positions are fixed: bit 1 reads as one, and bits 3, 5 and 12 to 15 read as zero, whatever is loaded. The word is presented on a single 16-bit output.

Top module: `status_flag_reg`

## Requirements
- R1: After a synchronous reset the flag word reads 16'h0002.
- R2: Bit 1 always reads 1, and bits 3, 5 and 12 to 15 always read 0, including after a parallel load that writes other values to them.
- R3: When `load_en` is high, on the next cycle the live bits (0, 2, 4, 6 to 11) equal those of `load_word`. This load takes priority over the ALU update and over the control strobes of the same cycle.
- R4: After an add (`op_class`=0) or subtract (`op_class`=1) with `upd_en` high, CF (bit 0) equals `carry_out`.
- R5: After any updating operation (`op_class` 0, 1 or 2), PF (bit 2) is 1 exactly when the low 8 bits of `result` hold an even number of ones, in both byte and word mode.
- R6: After any updating operation, ZF (bit 6) is 1 when `result[7:0]` is zero in byte mode (`is_word`=0) or `result[15:0]` is zero in word mode. SF (bit 7) is `result[7]` in byte mode and `result[15]` in word mode.
- R7: After an add or subtract, AF (bit 4) is the carry or borrow out of bit 3, that is `opnd_a[4]^opnd_b[4]^result[4]`.
- R8: After an add, OF (bit 11) is 1 when both operand sign bits are equal and the result sign differs from them. After a subtract (a minus b), OF is 1 when the operand signs differ and the result sign differs from that of `opnd_a`. The sign bit is bit 7 or bit 15 depending on `is_word`.
- R9: A logic operation (`op_class`=2) clears CF, AF and OF.
- R10: TF (bit 8), IF (bit 9) and DF (bit 10) are set by `ctl_set[0]`, `ctl_set[1]` and `ctl_set[2]` and cleared by the matching `ctl_clr` bits. Set wins when both are high. No ALU update changes them.
- R11: When `upd_en` is low, or `op_class` is 3, the six condition flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_en | input | 1 | Apply the condition flags of the current operation |
| op_class | input | 2 | 0 add, 1 subtract, 2 logic, 3 no update |
| is_word | input | 1 | 1 for a 16-bit operation, 0 for 8-bit |
| opnd_a | input | 16 | First operand (minuend for subtract) |
| opnd_b | input | 16 | Second operand |
| result | input | 16 | ALU result |
| carry_out | input | 1 | Carry or borrow out of the operation's top bit |
| ctl_set | input | 3 | Set strobes: bit 0 trap, bit 1 interrupt enable, bit 2 direction |
| ctl_clr | input | 3 | Clear strobes, same bit order as ctl_set |
| load_en | input | 1 | Load the whole word from load_word |
| load_word | input | 16 | Parallel load value |
| flags | output | 16 | Current flag word |

## Verification
The assertions check on every cycle that the fixed bits hold their constants. They also check that a load lands on the next cycle, that logic operations leave carry and overflow clear, that set strobes win, and that condition and control flags hold when nothing addresses them. What only the bench scenarios show is the value of each computed flag: parity over the low byte in word mode, a zero byte with a nonzero upper half, and the add and subtract overflow boundaries at 8 and 16 bits. These are compared against a reference built from the requirements.

// File: rtl/sflag_pkg.sv
package sflag_pkg;

    localparam int FLAG_W = 16;
    localparam int NCTL   = 3;

    // bit positions of the flag word
    localparam int POS_CY  = 0;
    localparam int POS_PAR = 2;
    localparam int POS_HC  = 4;
    localparam int POS_ZR  = 6;
    localparam int POS_SG  = 7;
    localparam int POS_CTL = 8;   // trap, int enable, direction at 8, 9, 10
    localparam int POS_OV  = 11;

    localparam logic [FLAG_W-1:0] FIXED_ONES = 16'h0002;
    localparam logic [FLAG_W-1:0] LIVE_MASK  = 16'h0FD5;

    typedef enum logic [1:0] {
        OPC_ADD   = 2'd0,
        OPC_SUB   = 2'd1,
        OPC_LOGIC = 2'd2,
        OPC_HOLD  = 2'd3
    } opc_t;

    typedef struct packed {
        logic ov;
        logic sg;
        logic zr;
        logic hc;
        logic par;
        logic cy;
    } cond_t;

    function automatic logic even_ones8(input logic [7:0] v);
        return ~(^v);
    endfunction

    function automatic logic [FLAG_W-1:0] pack_word(input cond_t c,
                                                    input logic [NCTL-1:0] k);
        logic [FLAG_W-1:0] w;
        w = FIXED_ONES;
        w[POS_CY]  = c.cy;
        w[POS_PAR] = c.par;
        w[POS_HC]  = c.hc;
        w[POS_ZR]  = c.zr;
        w[POS_SG]  = c.sg;
        w[POS_OV]  = c.ov;
        w[POS_CTL +: NCTL] = k;
        return w;
    endfunction

    function automatic cond_t unpack_cond(input logic [FLAG_W-1:0] w);
        cond_t c;
        c.cy  = w[POS_CY];
        c.par = w[POS_PAR];
        c.hc  = w[POS_HC];
        c.zr  = w[POS_ZR];
        c.sg  = w[POS_SG];
        c.ov  = w[POS_OV];
        return c;
    endfunction

endpackage

// File: rtl/sflag_cond_calc.sv
module sflag_cond_calc
    import sflag_pkg::*;
#(
    parameter int DW = 16
) (
    input  opc_t          opc,
    input  logic          is_word,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [DW-1:0] r,
    input  logic          cy_in,
    output logic          active,
    output cond_t         nxt
);
    localparam int HW    = DW / 2;
    localparam int NIB   = 4;

    logic sa, sb, sr;
    logic zero_lo, zero_hi;
    logic ov_add, ov_sub;

    always_comb begin
        sa = is_word ? a[DW-1] : a[HW-1];
        sb = is_word ? b[DW-1] : b[HW-1];
        sr = is_word ? r[DW-1] : r[HW-1];
        zero_lo = (r[HW-1:0] == '0);
        zero_hi = (r[DW-1:HW] == '0);
        ov_add  = (sa == sb) && (sr != sa);
        ov_sub  = (sa != sb) && (sr != sa);
    end

    always_comb begin
        active  = (opc != OPC_HOLD);
        nxt.par = even_ones8(r[7:0]);
        nxt.zr  = zero_lo && (zero_hi || !is_word);
        nxt.sg  = sr;
        unique case (opc)
            OPC_ADD: begin
                nxt.cy = cy_in;
                nxt.hc = a[NIB] ^ b[NIB] ^ r[NIB];
                nxt.ov = ov_add;
            end
            OPC_SUB: begin
                nxt.cy = cy_in;
                nxt.hc = a[NIB] ^ b[NIB] ^ r[NIB];
                nxt.ov = ov_sub;
            end
            default: begin
                nxt.cy = 1'b0;
                nxt.hc = 1'b0;
                nxt.ov = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sflag_ctrl_bits.sv
module sflag_ctrl_bits
    import sflag_pkg::*;
#(
    parameter int N = NCTL
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_en,
    input  logic [N-1:0] load_val,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= 1'b0;
            else if (load_en)
                q[i] <= load_val[i];
            else if (set_i[i])
                q[i] <= 1'b1;
            else if (clr_i[i])
                q[i] <= 1'b0;
        end

        AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
            (!load_en && set_i[i]) |=> q[i]) else $error("set strobe lost"); // R10
        AST_CLR_ONLY: assert property (@(posedge clk) disable iff (rst)
            (!load_en && !set_i[i] && clr_i[i]) |=> !q[i]) else $error("clear strobe lost"); // R10
    end

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!load_en && set_i == '0 && clr_i == '0) |=> $stable(q)) else $error("control bits moved"); // R10

endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg
    import sflag_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          upd_en,
    input  logic [1:0]    op_class,
    input  logic          is_word,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    input  logic [DW-1:0] result,
    input  logic          carry_out,
    input  logic [2:0]    ctl_set,
    input  logic [2:0]    ctl_clr,
    input  logic          load_en,
    input  logic [15:0]   load_word,
    output logic [15:0]   flags
);
    opc_t              opc;
    cond_t             cond_q;
    cond_t             cond_nxt;
    logic              cond_active;
    logic [NCTL-1:0]   ctrl_q;

    assign opc = opc_t'(op_class);

    sflag_cond_calc #(.DW(DW)) u_calc (
        .opc    (opc),
        .is_word(is_word),
        .a      (opnd_a),
        .b      (opnd_b),
        .r      (result),
        .cy_in  (carry_out),
        .active (cond_active),
        .nxt    (cond_nxt)
    );

    sflag_ctrl_bits #(.N(NCTL)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .load_en (load_en),
        .load_val(load_word[POS_CTL +: NCTL]),
        .set_i   (ctl_set),
        .clr_i   (ctl_clr),
        .q       (ctrl_q)
    );

    always_ff @(posedge clk) begin
        if (rst)
            cond_q <= '0;
        else if (load_en)
            cond_q <= unpack_cond(load_word);
        else if (upd_en && cond_active)
            cond_q <= cond_nxt;
    end

    assign flags = pack_word(cond_q, ctrl_q);

    AST_FIXED_BITS: assert property (@(posedge clk) disable iff (rst)
        (flags & ~LIVE_MASK) == FIXED_ONES) else $error("fixed bits wrong"); // R2
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        load_en |=> flags == (($past(load_word) & LIVE_MASK) | FIXED_ONES)) else $error("load lost"); // R3
    AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (!load_en && upd_en && op_class == 2'd2) |=> (!flags[POS_CY] && !flags[POS_OV] && !flags[POS_HC]))
        else $error("logic op left carry/overflow"); // R9
    AST_COND_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!load_en && (!upd_en || op_class == 2'd3)) |=> $stable(cond_q)) else $error("condition flags moved"); // R11

endmodule

// File: tb/status_flag_reg_test.sv
module status_flag_reg_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        upd_en;
    logic [1:0]  op_class;
    logic        is_word;
    logic [15:0] opnd_a, opnd_b, result;
    logic        carry_out;
    logic [2:0]  ctl_set, ctl_clr;
    logic        load_en;
    logic [15:0] load_word;
    logic [15:0] flags;

    int total = 0;
    int bad   = 0;
    logic [15:0] exp_w;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    status_flag_reg uut (
        .clk(clk), .rst(rst), .upd_en(upd_en), .op_class(op_class),
        .is_word(is_word), .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
        .carry_out(carry_out), .ctl_set(ctl_set), .ctl_clr(ctl_clr),
        .load_en(load_en), .load_word(load_word), .flags(flags)
    );

    // reference next value from the requirements
    function automatic logic [15:0] ref_next(input logic [15:0] p);
        logic [15:0] n;
        logic m_a, m_b, m_r;
        n = p;
        if (load_en) return (load_word & 16'h0FD5) | 16'h0002;
        if (upd_en && op_class != 2'd3) begin
            m_a = is_word ? opnd_a[15] : opnd_a[7];
            m_b = is_word ? opnd_b[15] : opnd_b[7];
            m_r = is_word ? result[15] : result[7];
            n[2] = ($countones(result[7:0]) % 2) == 0;
            n[6] = is_word ? (result == 16'h0) : (result[7:0] == 8'h0);
            n[7] = m_r;
            case (op_class)
                2'd0: begin n[0] = carry_out; n[4] = opnd_a[4]^opnd_b[4]^result[4];
                            n[11] = (m_a == m_b) && (m_r != m_a); end
                2'd1: begin n[0] = carry_out; n[4] = opnd_a[4]^opnd_b[4]^result[4];
                            n[11] = (m_a != m_b) && (m_r != m_a); end
                default: begin n[0] = 0; n[4] = 0; n[11] = 0; end
            endcase
        end
        for (int i = 0; i < 3; i++) begin
            if (ctl_set[i]) n[8+i] = 1'b1;
            else if (ctl_clr[i]) n[8+i] = 1'b0;
        end
        return n;
    endfunction

    task automatic chk(input string req, input logic [15:0] mask);
        total++;
        if ((flags & mask) !== (exp_w & mask)) begin
            bad++;
            $display("FAIL %s: flags=%h expected=%h (mask %h)", req, flags & mask, exp_w & mask, mask);
        end
    endtask

    task automatic check_all();
        chk("R2", 16'hF02A);
        chk("R4", 16'h0001);
        chk("R5", 16'h0004);
        chk("R7", 16'h0010);
        chk("R6", 16'h00C0);
        chk("R10", 16'h0700);
        chk("R8", 16'h0800);
    endtask

    task automatic idle_inputs();
        upd_en = 0; op_class = 2'd3; is_word = 0; opnd_a = 0; opnd_b = 0;
        result = 0; carry_out = 0; ctl_set = 0; ctl_clr = 0; load_en = 0; load_word = 0;
    endtask

    // inputs are set before the call (after a negedge); checks at the next negedge
    task automatic step();
        exp_w = ref_next(exp_w);
        @(posedge clk);
        @(negedge clk);
        check_all();
    endtask

    task automatic alu(input logic [1:0] oc, input logic w, input logic [15:0] a,
                       input logic [15:0] b, input logic [15:0] r, input logic c);
        idle_inputs();
        upd_en = 1; op_class = oc; is_word = w; opnd_a = a; opnd_b = b; result = r; carry_out = c;
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        idle_inputs();
        rst = 1;
        @(negedge clk); @(negedge clk);
        rst = 0;
        exp_w = 16'h0002;
        // R1 reset value
        chk("R1", 16'hFFFF);

        // R3 load of all ones: fixed bits stay (R2), load beats strobes and update
        idle_inputs(); load_en = 1; load_word = 16'hFFFF; ctl_clr = 3'b111;
        upd_en = 1; op_class = 2'd2; result = 16'h0001;
        step(); chk("R3", 16'hFFFF);
        idle_inputs(); load_en = 1; load_word = 16'h0000; ctl_set = 3'b111;
        step(); chk("R3", 16'hFFFF);

        // R5 parity of low byte in word mode, R6 byte zero with nonzero upper half
        alu(2'd0, 1, 16'h0100, 16'h0000, 16'hFF03, 0); chk("R5", 16'h0004);
        alu(2'd0, 0, 16'h1200, 16'h3400, 16'h4600, 0); chk("R6", 16'h00C0);
        alu(2'd0, 1, 16'h1200, 16'h3400, 16'h4600, 0); chk("R6", 16'h00C0);
        // R8 add overflow byte 7F+01, word 7FFF+0001
        alu(2'd0, 0, 16'h007F, 16'h0001, 16'h0080, 0); chk("R8", 16'h0800);
        alu(2'd0, 1, 16'h7FFF, 16'h0001, 16'h8000, 0); chk("R8", 16'h0800);
        // R8 subtract overflow 80-01 byte, R7 borrow from bit 4
        alu(2'd1, 0, 16'h0080, 16'h0001, 16'h007F, 0); chk("R8", 16'h0800);
        alu(2'd1, 1, 16'h0010, 16'h0001, 16'h000F, 0); chk("R7", 16'h0010);
        // R4 carry
        alu(2'd0, 0, 16'h00FF, 16'h0001, 16'h0000, 1); chk("R4", 16'h0001);
        // R9 logic clears CF, AF, OF
        alu(2'd2, 0, 16'h00FF, 16'h0001, 16'h0090, 1); chk("R9", 16'h0811);
        // R11 hold with op class 3 and with upd_en low
        alu(2'd0, 1, 16'h7FFF, 16'h0001, 16'h8000, 1);
        alu(2'd3, 1, 16'h0000, 16'h0000, 16'h0000, 0); chk("R11", 16'h08D5);
        idle_inputs(); op_class = 2'd0; result = 16'h0000; carry_out = 0;
        step(); chk("R11", 16'h08D5);
        // R10 set wins over clear, arithmetic does not touch control bits
        idle_inputs(); ctl_set = 3'b101; ctl_clr = 3'b111; step(); chk("R10", 16'h0700);
        alu(2'd2, 1, 16'h0, 16'h0, 16'h0, 0); chk("R10", 16'h0700);
        idle_inputs(); ctl_clr = 3'b001; step(); chk("R10", 16'h0700);

        // random mix
        for (int k = 0; k < 3000; k++) begin
            idle_inputs();
            upd_en    = ($urandom % 4) != 0;
            op_class  = 2'($urandom);
            is_word   = 1'($urandom);
            opnd_a    = 16'($urandom);
            opnd_b    = 16'($urandom);
            result    = (($urandom % 8) == 0) ? 16'($urandom % 2) << 8 : 16'($urandom);
            carry_out = 1'($urandom);
            ctl_set   = (($urandom % 3) == 0) ? 3'($urandom) : 3'b0;
            ctl_clr   = (($urandom % 3) == 0) ? 3'($urandom) : 3'b0;
            load_en   = ($urandom % 20) == 0;
            load_word = 16'($urandom);
            step();
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule